// File: doc/BRIEF.md
# Three-Wire Serial Divider Configuration Register

This block takes a configuration word over three slow pins: a serial clock, a serial data line and a load strobe. It keeps two divider settings for a frequency-synthesis loop, a 9-bit input (reference) divide ratio and a 10-bit feedback divide ratio, along with a loop-bandwidth selection bit. Bits are shifted in most-significant first. A rising load strobe copies the complete shifted word into the active settings. A falling load strobe freezes those settings. While the strobe is held high, the path is transparent and the active settings follow the shift register on every serial clock edge.

All three pins are asynchronous to the system clock. A two-flop synchronizer brings them into that domain and edges are detected there. Each pin must therefore hold each level for at least three system clock cycles. The two test bits in the word must be written as zero. A nonzero test bit in a loaded word sets a sticky error flag, but it does not stop the divider update.

Top module: `serdiv_cfg_port`

## Requirements
- R1: Each rising serial clock edge shifts the data pin into bit 0 of a 22-bit shift register, and older bits move one place up. After a full frame, bit 21 holds the mode bit (shifted first), bits 20 and 19 hold the two test bits, bits 18:10 hold the input divider value (MSB first) and bits 9:0 hold the feedback divider value (bit 0 shifted last).
- R2: While the load pin is low, shifting any number of bits leaves the divider outputs and the bandwidth output unchanged.
- R3: On a low-to-high load transition, the input divider output takes shift bits 18:10, the feedback divider output takes bits 9:0 and the bandwidth output takes bit 21.
- R4: After a high-to-low load transition, a complete new frame shifted in changes none of the active outputs.
- R5: While the load pin is high, every rising serial clock edge updates the active outputs from the shift register contents that include the bit just shifted.
- R6: After reset, the input divider output is 1, the feedback divider output is 32, the bandwidth output is 1 and the error flag is 0.
- R7: The bandwidth output equals the loaded mode bit: 1 means normal bandwidth and 0 means narrow bandwidth.
- R8: When a loaded word has a nonzero test bit (shift bit 20 or 19), the error flag goes to 1 and stays at 1 until reset, and the divider values in that word are still applied.
- R9: When a load rise and a serial clock rise are detected in the same system cycle, the active outputs take the shift register contents after that shift, not before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock pin, shifts on its rising edge |
| ser_dat_i | input | 1 | Serial data pin |
| ser_ld_i | input | 1 | Load strobe pin: rise transfers, high is transparent, fall freezes |
| r_div_o | output | 9 | Active input divider value |
| m_div_o | output | 10 | Active feedback divider value |
| bw_normal_o | output | 1 | 1 for normal loop bandwidth, 0 for narrow |
| test_err_o | output | 1 | Sticky flag for a loaded word with nonzero test bits |

## Verification
Two functions can fall in the same system cycle: the load transfer and a shift. When both synchronized edges are detected together, the transfer must use the word after the shift. The bench provokes this by shifting 21 bits of a frame, presenting the last bit, and then raising the load and serial clock pins at the same instant so that both pass through the synchronizer together. The result is judged by comparing the outputs with the full 22-bit frame. The word before the shift would give different divider values.

// File: rtl/serdiv_pkg.sv
package serdiv_pkg;
  localparam int MODE_W   = 3;
  localparam int R_W      = 9;
  localparam int M_W      = 10;
  localparam int FRAME_W  = MODE_W + R_W + M_W;
  localparam int M_LSB    = 0;
  localparam int R_LSB    = M_W;
  localparam int MODE_LSB = M_W + R_W;
  localparam int PIN_W    = 3;

  typedef logic [FRAME_W-1:0] frame_t;

  function automatic logic [R_W-1:0] frame_r(input frame_t f);
    return f[R_LSB +: R_W];
  endfunction

  function automatic logic [M_W-1:0] frame_m(input frame_t f);
    return f[M_LSB +: M_W];
  endfunction

  function automatic logic frame_bw(input frame_t f);
    return f[FRAME_W-1];
  endfunction

  // Test bits sit just below the bandwidth bit.
  function automatic logic frame_test_bad(input frame_t f);
    return |f[MODE_LSB +: MODE_W-1];
  endfunction
endpackage

// File: rtl/serdiv_sync.sv
module serdiv_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/serdiv_edge.sv
module serdiv_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
endmodule

// File: rtl/serdiv_shift.sv
module serdiv_shift #(
  parameter int W = 22
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] q,
  output logic [W-1:0] nxt
);
  assign nxt = {q[W-2:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= nxt;
  end
endmodule

// File: rtl/serdiv_cfg_port.sv
module serdiv_cfg_port
  import serdiv_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int R_RST       = 1,
  parameter int M_RST       = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ser_clk_i,
  input  logic           ser_dat_i,
  input  logic           ser_ld_i,
  output logic [R_W-1:0] r_div_o,
  output logic [M_W-1:0] m_div_o,
  output logic           bw_normal_o,
  output logic           test_err_o
);
  localparam logic [R_W-1:0] R_DEF = R_W'(R_RST);
  localparam logic [M_W-1:0] M_DEF = M_W'(M_RST);

  logic [PIN_W-1:0] pins_s;
  logic             sclk_lvl, sdat_lvl, ld_lvl;
  logic [1:0]       rises;
  logic             sclk_rise, ld_rise;
  frame_t           shift_q, shift_nxt, upd_frame;
  logic             pass_shift, act_upd;

  serdiv_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ser_ld_i, ser_dat_i, ser_clk_i}),
    .q(pins_s)
  );

  assign sclk_lvl = pins_s[0];
  assign sdat_lvl = pins_s[1];
  assign ld_lvl   = pins_s[2];

  serdiv_edge #(.W(2)) u_edge (
    .clk(clk), .rst_n(rst_n),
    .lvl({ld_lvl, sclk_lvl}),
    .rise(rises)
  );

  assign sclk_rise = rises[0];
  assign ld_rise   = rises[1];

  serdiv_shift #(.W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .en(sclk_rise), .din(sdat_lvl),
    .q(shift_q), .nxt(shift_nxt)
  );

  // A shift seen with load high (including its rising cycle) updates
  // the active word with the post-shift contents.
  assign pass_shift = sclk_rise && ld_lvl;
  assign act_upd    = ld_rise || pass_shift;
  assign upd_frame  = pass_shift ? shift_nxt : shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_div_o     <= R_DEF;
      m_div_o     <= M_DEF;
      bw_normal_o <= 1'b1;
      test_err_o  <= 1'b0;
    end else if (act_upd) begin
      r_div_o     <= frame_r(upd_frame);
      m_div_o     <= frame_m(upd_frame);
      bw_normal_o <= frame_bw(upd_frame);
      test_err_o  <= test_err_o | frame_test_bad(upd_frame);
    end
  end
endmodule

// File: rtl/serdiv_cfg_chk.sv
module serdiv_cfg_chk
  import serdiv_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           sclk_rise,
  input logic           sdat_lvl,
  input logic           ld_lvl,
  input logic           ld_rise,
  input frame_t         shift_q,
  input logic [R_W-1:0] r_div_o,
  input logic [M_W-1:0] m_div_o,
  input logic           bw_normal_o,
  input logic           test_err_o
);
  assert_shift_in_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |=> (shift_q[0] == $past(sdat_lvl)) &&
                  (shift_q[FRAME_W-1:1] == $past(shift_q[FRAME_W-2:0])));

  // Covers R2 as well: a low load level never lets outputs move.
  assert_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_lvl |=> $stable(r_div_o) && $stable(m_div_o) && $stable(bw_normal_o));

  assert_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_rise && !sclk_rise) |=>
      (r_div_o == $past(shift_q[R_LSB +: R_W])) &&
      (m_div_o == $past(shift_q[M_LSB +: M_W])) &&
      (bw_normal_o == $past(shift_q[FRAME_W-1])));

  // Also R9: a load rise together with a shift takes the shifted word.
  assert_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_lvl && sclk_rise) |=>
      (r_div_o == shift_q[R_LSB +: R_W]) && (m_div_o == shift_q[M_LSB +: M_W]));

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    test_err_o |=> test_err_o);

  assert_err_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_rise && !sclk_rise && (shift_q[FRAME_W-2] || shift_q[FRAME_W-3])) |=> test_err_o);
endmodule

bind serdiv_cfg_port serdiv_cfg_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .sclk_rise(sclk_rise), .sdat_lvl(sdat_lvl),
  .ld_lvl(ld_lvl), .ld_rise(ld_rise),
  .shift_q(shift_q),
  .r_div_o(r_div_o), .m_div_o(m_div_o),
  .bw_normal_o(bw_normal_o), .test_err_o(test_err_o)
);

// File: tb/test_serdiv_cfg_port.sv
module test_serdiv_cfg_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_clk_i = 1'b0, ser_dat_i = 1'b0, ser_ld_i = 1'b0;
  logic [8:0] r_div_o;
  logic [9:0] m_div_o;
  logic       bw_normal_o, test_err_o;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [21:0] m_sh = '0;

  always #2 clk = ~clk;

  serdiv_cfg_port i_serdiv_cfg_port (
    .clk(clk), .rst_n(rst_n),
    .ser_clk_i(ser_clk_i), .ser_dat_i(ser_dat_i), .ser_ld_i(ser_ld_i),
    .r_div_o(r_div_o), .m_div_o(m_div_o),
    .bw_normal_o(bw_normal_o), .test_err_o(test_err_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ser_bit(input logic b);
    ser_dat_i = b;  wait_n(4);
    ser_clk_i = 1'b1; wait_n(4);
    ser_clk_i = 1'b0; wait_n(4);
    m_sh = {m_sh[20:0], b};
  endtask

  task automatic shift_frame(input logic [21:0] f);
    for (int i = 21; i >= 0; i--) ser_bit(f[i]);
  endtask

  task automatic set_ld(input logic v);
    ser_ld_i = v; wait_n(6);
  endtask

  function automatic logic [21:0] mk(input logic [2:0] md, input int r, input int m);
    return {md, 9'(r), 10'(m)};
  endfunction

  task automatic t_reset;
    check("R6 r reset", r_div_o, 1);
    check("R6 m reset", m_div_o, 32);
    check("R6 bw reset", bw_normal_o, 1);
    check("R6 err reset", test_err_o, 0);
  endtask

  task automatic t_shift_hold;
    shift_frame(mk(3'b100, 300, 700));
    check("R2 r held", r_div_o, 1);
    check("R2 m held", m_div_o, 32);
  endtask

  task automatic t_load;
    set_ld(1'b1);
    check("R3 r loaded", r_div_o, 300);
    check("R3 m loaded (R1 order)", m_div_o, 700);
    check("R7 bw normal", bw_normal_o, 1);
    check("R8 err clean", test_err_o, 0);
    set_ld(1'b0);
  endtask

  task automatic t_freeze;
    shift_frame(mk(3'b000, 5, 6));
    check("R4 r frozen", r_div_o, 300);
    check("R4 m frozen", m_div_o, 700);
    check("R4 bw frozen", bw_normal_o, 1);
    set_ld(1'b1);
    check("R3 r second load", r_div_o, 5);
    check("R3 m second load", m_div_o, 6);
    check("R7 bw narrow", bw_normal_o, 0);
    set_ld(1'b0);
  endtask

  task automatic t_pass;
    logic [9:0] pat = 10'b1011001110;
    set_ld(1'b1);
    for (int i = 9; i >= 0; i--) begin
      ser_bit(pat[i]);
      check("R5 r follows", r_div_o, int'(m_sh[18:10]));
      check("R5 m follows", m_div_o, int'(m_sh[9:0]));
      check("R5 bw follows", bw_normal_o, int'(m_sh[21]));
    end
    set_ld(1'b0);
    begin
      logic [8:0] r_keep = m_sh[18:10];
      logic [9:0] m_keep = m_sh[9:0];
      ser_bit(1'b1); ser_bit(1'b0); ser_bit(1'b1);
      check("R4 r after fall", r_div_o, int'(r_keep));
      check("R4 m after fall", m_div_o, int'(m_keep));
    end
  endtask

  task automatic t_err;
    shift_frame(mk(3'b110, 511, 1023));
    set_ld(1'b1);
    check("R8 err set", test_err_o, 1);
    check("R8 r still applied", r_div_o, 511);
    check("R8 m still applied", m_div_o, 1023);
    set_ld(1'b0);
    shift_frame(mk(3'b100, 1, 4));
    set_ld(1'b1);
    check("R8 err sticky", test_err_o, 1);
    check("R3 r min", r_div_o, 1);
    check("R3 m min", m_div_o, 4);
    set_ld(1'b0);
  endtask

  task automatic t_same;
    logic [21:0] f = mk(3'b100, 17, 33);
    for (int i = 21; i >= 1; i--) ser_bit(f[i]);
    ser_dat_i = f[0]; wait_n(4);
    ser_ld_i = 1'b1; ser_clk_i = 1'b1; wait_n(6);
    m_sh = {m_sh[20:0], f[0]};
    check("R9 r post-shift", r_div_o, 17);
    check("R9 m post-shift", m_div_o, 33);
    check("R9 bw post-shift", bw_normal_o, 1);
    ser_clk_i = 1'b0; wait_n(4);
    set_ld(1'b0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    wait_n(5);
    rst_n = 1'b1;
    wait_n(3);
    t_reset();
    t_shift_hold();
    t_load();
    t_freeze();
    t_pass();
    t_err();
    t_same();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end
endmodule